// File: doc/BRIEF.md
# Video Stream Clock-Enable Cadence Generator

This block produces the clock enable that paces elementary video data streams when the word clock runs faster than the stream word rate. It runs on the serial link's parallel word clock. The link standard and the number of active elementary streams choose one of four cadences. The enable can be high on every clock, on every second clock, or on every fourth clock. For standard definition it uses an uneven cadence whose gaps alternate between five and six clocks, which averages one pulse every 5.5 clocks.

Both selectors are sampled on every clock. When either one changes, the cadence restarts from a known phase, so the datapath downstream sees a predictable first pulse after a reconfiguration. A selector pair that has no defined cadence raises an error flag and keeps the enable low. Both outputs come straight from flip-flops.

Top module: `sdce_cadence_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `ce_o` and `cfg_err_o` read 0 after that edge. After release, the first edge that samples the selectors keeps `ce_o` low, and the next edge raises it for a supported pair.
- R2: With `mode_i`=0 (standard definition) and `streams_i`=0 (one stream), the gaps between enable pulses alternate 5, 6, 5, 6 clocks, and the first gap after a restart is 5.
- R3: With `mode_i`=1 (HD, `streams_i`=1, two streams) or `mode_i`=2 (3G level A, `streams_i`=1), the enable is high on every clock.
- R4: With `mode_i`=3 (3G level B) and `streams_i`=2 (four streams), the enable is high on every second clock.
- R5: With `mode_i`=4 (6G), `streams_i`=2 (four streams) gives an enable on every clock and `streams_i`=3 (eight streams) gives one on every second clock.
- R6: With `mode_i`=5 (12G), `streams_i`=3 (eight streams) gives an enable on every second clock and `streams_i`=4 (sixteen streams) gives one on every fourth clock.
- R7: In every cadence whose gap is 2 or more, each pulse is high for exactly one clock.
- R8: When the edge at clock N samples a selector pair that differs from the pair sampled at the previous edge, `ce_o` is low after edge N. For a supported pair it is high after edge N+1, and the cadence continues from there.
- R9: An unsupported pair sets `cfg_err_o` from the edge that samples it and holds `ce_o` low for as long as the pair stays. The edge that samples a supported pair clears the flag.
- R10: `streams_i` is the base-2 logarithm of the stream count. Any pair not listed in R2 to R6 is unsupported. This includes `mode_i` values 6 and 7, `streams_i` values 5 to 7, and a stream count that does not match the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | MODE_W | Link standard selector (0 SD, 1 HD, 2 3G-A, 3 3G-B, 4 6G, 5 12G) |
| streams_i | input | SEL_W | Log2 of the number of active elementary streams |
| ce_o | output | 1 | Registered stream clock enable |
| cfg_err_o | output | 1 | Registered flag for an unsupported selector pair |

## Verification
A wrong gap count or a stuck alternation bit shows up as a mismatched pulse spacing at `ce_o` within the first one or two gaps after a restart. That is at most twelve clocks for the uneven cadence and four clocks for the others. A missed change detection shows as a pulse in the cycle right after the new selectors are sampled, or as a missing pulse one cycle later, so it is seen within two clocks. A decode fault either leaves `cfg_err_o` wrong one edge after the selectors are applied or produces a cadence with the wrong spacing. Both are visible in the first window of pulses after each table entry is applied.

// File: rtl/sdce_pkg.sv
package sdce_pkg;

  typedef enum logic [1:0] {
    CAD_EVERY   = 2'd0,
    CAD_HALF    = 2'd1,
    CAD_QUARTER = 2'd2,
    CAD_ALT     = 2'd3
  } cadence_e;

  typedef struct packed {
    logic     bad;
    cadence_e cad;
  } cad_cfg_t;

  localparam logic [7:0] LNK_SD  = 8'd0;
  localparam logic [7:0] LNK_HD  = 8'd1;
  localparam logic [7:0] LNK_3GA = 8'd2;
  localparam logic [7:0] LNK_3GB = 8'd3;
  localparam logic [7:0] LNK_6G  = 8'd4;
  localparam logic [7:0] LNK_12G = 8'd5;

endpackage

// File: rtl/sdce_decode.sv
module sdce_decode
  import sdce_pkg::*;
#(
  parameter int MODE_W = 3,
  parameter int SEL_W  = 3
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [SEL_W-1:0]  sel,
  output cad_cfg_t          cfg
);

  logic [7:0] m8;
  logic [7:0] s8;

  always_comb begin
    m8 = 8'(mode);
    s8 = 8'(sel);
    cfg.bad = 1'b0;
    cfg.cad = CAD_EVERY;
    case (m8)
      LNK_SD:  if (s8 == 8'd0) cfg.cad = CAD_ALT;   else cfg.bad = 1'b1;
      LNK_HD:  if (s8 == 8'd1) cfg.cad = CAD_EVERY; else cfg.bad = 1'b1;
      LNK_3GA: if (s8 == 8'd1) cfg.cad = CAD_EVERY; else cfg.bad = 1'b1;
      LNK_3GB: if (s8 == 8'd2) cfg.cad = CAD_HALF;  else cfg.bad = 1'b1;
      LNK_6G: begin
        if (s8 == 8'd2)      cfg.cad = CAD_EVERY;
        else if (s8 == 8'd3) cfg.cad = CAD_HALF;
        else                 cfg.bad = 1'b1;
      end
      LNK_12G: begin
        if (s8 == 8'd3)      cfg.cad = CAD_HALF;
        else if (s8 == 8'd4) cfg.cad = CAD_QUARTER;
        else                 cfg.bad = 1'b1;
      end
      default: cfg.bad = 1'b1;
    endcase
  end

  // R10: stream counts above sixteen never decode as supported
  always_comb begin
    if (s8 > 8'd4) begin
      assert_wide_sel_bad_R10: assert (cfg.bad);
    end
  end

endmodule

// File: rtl/sdce_track.sv
module sdce_track
  import sdce_pkg::*;
#(
  parameter int MODE_W = 3,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic [SEL_W-1:0]  sel,
  output logic              hold,
  output logic              restart_q,
  output cad_cfg_t          cfg_q
);

  localparam int CFG_W = MODE_W + SEL_W;

  logic [CFG_W-1:0] seen_q;
  logic             valid_q;
  cad_cfg_t         cfg_raw;

  sdce_decode #(.MODE_W(MODE_W), .SEL_W(SEL_W)) u_dec (
    .mode (mode),
    .sel  (sel),
    .cfg  (cfg_raw)
  );

  assign hold = !valid_q || ({mode, sel} != seen_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      seen_q    <= '0;
      restart_q <= 1'b0;
      cfg_q     <= '0;
    end else begin
      valid_q   <= 1'b1;
      seen_q    <= {mode, sel};
      restart_q <= hold;
      if (hold) cfg_q <= cfg_raw;
    end
  end

  // R9: the decoded setting only moves on an edge that saw new selectors
  assert_cfg_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (!hold && valid_q) |=> $stable(cfg_q));

endmodule

// File: rtl/sdce_gap_timer.sv
module sdce_gap_timer
  import sdce_pkg::*;
#(
  parameter int SHORT_GAP = 5,
  parameter int LONG_GAP  = 6
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     hold,
  input  logic     restart,
  input  cad_cfg_t cfg,
  output logic     ce_q
);

  localparam int MAXG  = (LONG_GAP > 4) ? LONG_GAP : 4;
  localparam int CNT_W = $clog2(MAXG + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] gap;
  logic             long_q;

  always_comb begin
    case (cfg.cad)
      CAD_EVERY:   gap = CNT_W'(1);
      CAD_HALF:    gap = CNT_W'(2);
      CAD_QUARTER: gap = CNT_W'(4);
      default:     gap = long_q ? CNT_W'(LONG_GAP) : CNT_W'(SHORT_GAP);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b0;
      cnt_q  <= CNT_W'(1);
      long_q <= 1'b0;
    end else if (hold) begin
      ce_q <= 1'b0;
    end else if (cfg.bad) begin
      ce_q  <= 1'b0;
      cnt_q <= CNT_W'(1);
    end else if (restart) begin
      ce_q   <= 1'b1;
      cnt_q  <= CNT_W'(1);
      long_q <= 1'b0;
    end else if (cnt_q == gap) begin
      ce_q   <= 1'b1;
      cnt_q  <= CNT_W'(1);
      long_q <= ~long_q;
    end else begin
      ce_q  <= 1'b0;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R8: new selectors silence the enable for one cycle
  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    hold |=> !ce_q);

  // R8: a stable supported setting after a change pulses at once
  assert_restart_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (restart && !hold && !cfg.bad) |=> ce_q);

  // R9: an unsupported setting keeps the enable low
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    cfg.bad |-> !ce_q);

  // R7: spaced cadences give single-cycle pulses
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (ce_q && !hold && !restart && cfg.cad != CAD_EVERY) |=> !ce_q);

endmodule

// File: rtl/sdce_cadence_gen.sv
module sdce_cadence_gen
  import sdce_pkg::*;
#(
  parameter int MODE_W    = 3,
  parameter int SEL_W     = 3,
  parameter int SHORT_GAP = 5,
  parameter int LONG_GAP  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SEL_W-1:0]  streams_i,
  output logic              ce_o,
  output logic              cfg_err_o
);

  logic     hold;
  logic     restart_q;
  cad_cfg_t cfg_q;

  sdce_track #(.MODE_W(MODE_W), .SEL_W(SEL_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_i),
    .sel       (streams_i),
    .hold      (hold),
    .restart_q (restart_q),
    .cfg_q     (cfg_q)
  );

  sdce_gap_timer #(.SHORT_GAP(SHORT_GAP), .LONG_GAP(LONG_GAP)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold),
    .restart (restart_q),
    .cfg     (cfg_q),
    .ce_q    (ce_o)
  );

  assign cfg_err_o = cfg_q.bad;

  // R9: the flag and the enable are never high together
  assert_no_ce_with_err_R9: assert property (@(posedge clk) disable iff (rst)
    !(ce_o && cfg_err_o));

  // R1: reset clears both outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!ce_o && !cfg_err_o));

endmodule

// File: tb/sdce_cadence_gen_test.sv
module sdce_cadence_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  localparam int WIN  = 24;

  // {mode[3], streams[3], err, gap_a[4], gap_b[4]}
  localparam logic [14:0] VEC [0:NVEC-1] = '{
    {3'd0, 3'd0, 1'b0, 4'd5, 4'd6},
    {3'd1, 3'd1, 1'b0, 4'd1, 4'd1},
    {3'd0, 3'd1, 1'b1, 4'd0, 4'd0},
    {3'd2, 3'd1, 1'b0, 4'd1, 4'd1},
    {3'd3, 3'd2, 1'b0, 4'd2, 4'd2},
    {3'd3, 3'd1, 1'b1, 4'd0, 4'd0},
    {3'd4, 3'd2, 1'b0, 4'd1, 4'd1},
    {3'd4, 3'd3, 1'b0, 4'd2, 4'd2},
    {3'd4, 3'd5, 1'b1, 4'd0, 4'd0},
    {3'd5, 3'd3, 1'b0, 4'd2, 4'd2},
    {3'd5, 3'd4, 1'b0, 4'd4, 4'd4},
    {3'd5, 3'd2, 1'b1, 4'd0, 4'd0},
    {3'd6, 3'd1, 1'b1, 4'd0, 4'd0},
    {3'd7, 3'd3, 1'b1, 4'd0, 4'd0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_i = 3'd0;
  logic [2:0] streams_i = 3'd0;
  logic       ce_o;
  logic       cfg_err_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdce_cadence_gen uut (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .streams_i (streams_i),
    .ce_o      (ce_o),
    .cfg_err_o (cfg_err_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_req(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual 0 expected 1 (run finished)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    step();
    step();
    chk(ce_o == 1'b0, "R1 ce in reset", ce_o, 0);
    chk(cfg_err_o == 1'b0, "R1 err in reset", cfg_err_o, 0);

    rst = 1'b0;
    mode_i = 3'd1;
    streams_i = 3'd1;
    step();
    chk(ce_o == 1'b0, "R1 first sampling edge", ce_o, 0);
    step();
    chk(ce_o == 1'b1, "R1 first pulse", ce_o, 1);

    // Table walk: R2..R10, with R7/R8/R9 on every entry
    for (int v = 0; v < NVEC; v++) begin
      logic [14:0] e;
      logic        bad;
      int          ga, gb, last;
      logic        want_b, prev;
      e   = VEC[v];
      bad = e[8];
      ga  = int'(e[7:4]);
      gb  = int'(e[3:0]);
      mode_i    = e[14:12];
      streams_i = e[11:9];
      step();
      chk(ce_o == 1'b0, "R8 quiet after change", ce_o, 0);
      chk(cfg_err_o == bad, bad ? "R9 flag set" : "R9 flag clear", cfg_err_o, bad);
      step();
      chk(ce_o == !bad, "R8 restart pulse", ce_o, !bad);
      last = 0;
      want_b = 1'b0;
      prev = ce_o;
      for (int i = 1; i <= WIN; i++) begin
        step();
        if (bad) begin
          chk(ce_o == 1'b0, "R9 enable held low", ce_o, 0);
          chk(cfg_err_o == 1'b1, "R10 unsupported pair flagged", cfg_err_o, 1);
        end else begin
          if (ga > 1 && prev && ce_o)
            chk(1'b0, "R7 pulse width", 2, 1);
          if (ce_o) begin
            int g;
            g = i - last;
            chk(g == (want_b ? gb : ga), mode_req(e[14:12]), g, want_b ? gb : ga);
            want_b = !want_b;
            last = i;
          end
        end
        prev = ce_o;
      end
      if (!bad) chk(last > 0, "R8 cadence continues", last, 1);
    end

    // R8: selectors changing every cycle keep the enable low
    for (int k = 0; k < 6; k++) begin
      mode_i    = (k % 2 == 0) ? 3'd1 : 3'd3;
      streams_i = (k % 2 == 0) ? 3'd1 : 3'd2;
      step();
      chk(ce_o == 1'b0, "R8 rapid change", ce_o, 0);
    end
    step();
    chk(ce_o == 1'b1, "R8 pulse after settling", ce_o, 1);

    // R2: standard-definition restart begins with the short gap again
    mode_i = 3'd0;
    streams_i = 3'd0;
    step();
    step();
    chk(ce_o == 1'b1, "R2 restart pulse", ce_o, 1);
    begin
      int first_gap;
      first_gap = 0;
      for (int i = 1; i <= 8; i++) begin
        step();
        if (ce_o && first_gap == 0) first_gap = i;
      end
      chk(first_gap == 5, "R2 first gap after restart", first_gap, 5);
    end

    // R9: leaving an unsupported pair clears the flag at once
    mode_i = 3'd7;
    step();
    chk(cfg_err_o == 1'b1, "R9 flag on mode 7", cfg_err_o, 1);
    mode_i = 3'd5;
    streams_i = 3'd4;
    step();
    chk(cfg_err_o == 1'b0, "R9 flag cleared", cfg_err_o, 0);
    step();
    chk(ce_o == 1'b1, "R6 pulse after error exit", ce_o, 1);

    // R1: reset mid-run, then resume
    rst = 1'b1;
    step();
    chk(ce_o == 1'b0, "R1 mid-run reset ce", ce_o, 0);
    chk(cfg_err_o == 1'b0, "R1 mid-run reset err", cfg_err_o, 0);
    rst = 1'b0;
    step();
    chk(ce_o == 1'b0, "R1 resume sampling edge", ce_o, 0);
    step();
    chk(ce_o == 1'b1, "R1 resume pulse", ce_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule